// File: doc/BRIEF.md
# DDR Command Interval Enforcer

This block sits between a DDR command scheduler and the command bus. It does not choose commands. It only holds back the command now offered until the required minimum spacing to earlier events on the same chip select has passed. Four intervals are enforced:

- refresh to activate;
- last write data to precharge;
- activate to activate on a different bank;
- last write data to read.

Each chip select keeps its own set of down-counters, so traffic to one rank never stalls another rank.

The scheduler offers one command per cycle on `cmd_valid` with its type, chip select and bank. `cmd_ready` is computed combinationally from the counters of the addressed chip select. A command is taken on a cycle where both are high. The data path reports the last write data pair of each chip select on a per-chip-select strobe, and the write-based intervals start from that strobe.

The interval lengths come from configuration inputs. These are copied into shadow registers only while every counter in the block is idle. A reserved zero setting is replaced by one clock and raises a sticky error flag.

Top module: `ddr_cmd_gap_enforcer`

## Requirements
- R1: The refresh recovery length is N = {cfg_rfc_hi, cfg_rfc_lo} + 8 clocks, so it ranges from 8 to 135. The hi field is 3 bits and forms the upper bits; the lo field is 4 bits. After a REFRESH (cmd_type 4) is accepted on chip select c at clock edge k, an ACTIVATE (cmd_type 0) to c is not accepted before edge k+N, and it is ready from edge k+N on.
- R2: After wr_last[c] is high at edge k, a PRECHARGE (cmd_type 1) to c is not accepted before edge k+W, where W is cfg_wr_rec (1 to 7).
- R3: After an ACTIVATE to bank b on chip select c is accepted at edge k, an ACTIVATE to any other bank of c is not accepted before edge k+A, where A is cfg_act_gap (1 to 7). A further ACTIVATE to bank b itself is not limited by this interval.
- R4: After wr_last[c] is high at edge k, a READ (cmd_type 2) to c is not accepted before edge k+T, where T is cfg_wr_to_rd (1 to 7).
- R5: A zero in cfg_wr_rec, cfg_act_gap or cfg_wr_to_rd acts as one clock. Capturing such a zero sets cfg_err, and cfg_err stays high until reset.
- R6: Intervals running on one chip select never lower cmd_ready for a command addressed to another chip select.
- R7: cmd_ready is low while the offered command violates a running interval. The command is not consumed, and it is accepted in the first cycle the interval allows. WRITE (cmd_type 3), REFRESH and the unused codes 5 to 7 are always ready.
- R8: The configuration inputs are copied to the shadow settings at a clock edge only if every interval counter of every chip select was zero in the cycle before. An interval started while any counter runs uses the previous settings.
- R9: While and after reset, with no interval running, cmd_ready is high for every command type and cfg_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_type | input | 3 | 0 activate, 1 precharge, 2 read, 3 write, 4 refresh |
| cmd_cs | input | 2 | Target chip select |
| cmd_bank | input | 3 | Target bank |
| cmd_ready | output | 1 | Offered command may issue this cycle |
| wr_last | input | 4 | Per chip select, last write data pair strobe |
| cfg_rfc_lo | input | 4 | Refresh recovery, low bits |
| cfg_rfc_hi | input | 3 | Refresh recovery, high bits |
| cfg_wr_rec | input | 3 | Write data to precharge clocks |
| cfg_act_gap | input | 3 | Activate to activate (different bank) clocks |
| cfg_wr_to_rd | input | 3 | Write data to read clocks |
| cfg_err | output | 1 | Sticky reserved-setting flag |

## Verification
The hardest condition to reach from the ports is R8: a configuration change that arrives while some counter on an unrelated chip select is still running, followed by a new interval started under the old shadow settings. The random stimulus rarely keeps all counters idle at the right moment. A directed sequence therefore starts a long refresh interval on one chip select, changes the write recovery setting, and fires a write data strobe on another chip select. It then checks that the old value governs. After the block drains, it checks that the new value takes over. Long random runs, with the settings reprogrammed every 200 cycles and a bench model of the counters and shadow capture, cover the mixing of all four intervals.

// File: rtl/ddr_gap_pkg.sv
// Shared constants and command encoding for the DDR interval enforcer.
package ddr_gap_pkg;
    localparam int RFC_LO_W   = 4;
    localparam int RFC_HI_W   = 3;
    localparam int RFC_W      = RFC_LO_W + RFC_HI_W;
    localparam int RFC_CNT_W  = RFC_W + 1;
    localparam int RFC_ADDER  = 8;
    localparam int GAP_W      = 3;
    localparam int CMD_W      = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_ACT = 3'd0,
        CMD_PRE = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_REF = 3'd4
    } ddr_cmd_e;
endpackage

// File: rtl/ddr_gap_downcnt.sv
// Loadable down-counter that stops at zero.
// Assumes: load takes priority over counting; zero means the interval is over.
module ddr_gap_downcnt #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);
    logic [WIDTH-1:0] cnt_q;

    // Count down toward zero, restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_gap_cfg_shadow.sv
// Shadow copy of the interval settings plus decoding into counter loads.
// Assumes: capture_en is high only when all interval counters are idle.
// A load value is the interval length minus one, so a command accepted at
// edge k frees the next one at edge k+length.
module ddr_gap_cfg_shadow
    import ddr_gap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture_en,
    input  logic [RFC_LO_W-1:0]  raw_rfc_lo,
    input  logic [RFC_HI_W-1:0]  raw_rfc_hi,
    input  logic [GAP_W-1:0]     raw_wr,
    input  logic [GAP_W-1:0]     raw_rrd,
    input  logic [GAP_W-1:0]     raw_wtr,
    output logic [RFC_CNT_W-1:0] rfc_load,
    output logic [GAP_W-1:0]     wr_load,
    output logic [GAP_W-1:0]     rrd_load,
    output logic [GAP_W-1:0]     wtr_load,
    output logic                 cfg_err
);
    logic [RFC_W-1:0] rfc_q;
    logic [GAP_W-1:0] wr_q;
    logic [GAP_W-1:0] rrd_q;
    logic [GAP_W-1:0] wtr_q;
    logic             err_q;
    logic             raw_bad;

    // Reserved zero in any short field.
    assign raw_bad = (raw_wr == '0) || (raw_rrd == '0) || (raw_wtr == '0);

    // Shadow capture and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfc_q <= '0;
            wr_q  <= GAP_W'(1);
            rrd_q <= GAP_W'(1);
            wtr_q <= GAP_W'(1);
            err_q <= 1'b0;
        end else if (capture_en) begin
            rfc_q <= {raw_rfc_hi, raw_rfc_lo};
            wr_q  <= raw_wr;
            rrd_q <= raw_rrd;
            wtr_q <= raw_wtr;
            err_q <= err_q | raw_bad;
        end
    end

    // Length minus one; reserved zero behaves as length one.
    function automatic logic [GAP_W-1:0] gap_to_load(input logic [GAP_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Decode the shadow settings into counter loads.
    always_comb begin
        rfc_load = RFC_CNT_W'(rfc_q) + RFC_CNT_W'(RFC_ADDER - 1);
        wr_load  = gap_to_load(wr_q);
        rrd_load = gap_to_load(rrd_q);
        wtr_load = gap_to_load(wtr_q);
    end

    assign cfg_err = err_q;
endmodule

// File: rtl/ddr_gap_cs_timer.sv
// Interval counters for one chip select: refresh recovery, write recovery,
// activate spacing and write-to-read, plus the last activated bank.
// Assumes: accept strobes are already qualified with this chip select.
module ddr_gap_cs_timer
    import ddr_gap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_acc,
    input  logic                 ref_acc,
    input  logic                 wr_last,
    input  logic [BANK_W-1:0]    bank_in,
    input  logic [RFC_CNT_W-1:0] rfc_load,
    input  logic [GAP_W-1:0]     wr_load,
    input  logic [GAP_W-1:0]     rrd_load,
    input  logic [GAP_W-1:0]     wtr_load,
    output logic                 act_ok,
    output logic                 pre_ok,
    output logic                 rd_ok,
    output logic                 idle
);
    logic              rfc_zero;
    logic              wr_zero;
    logic              rrd_zero;
    logic              wtr_zero;
    logic [BANK_W-1:0] last_bank_q;

    ddr_gap_downcnt #(.WIDTH(RFC_CNT_W)) u_rfc (
        .clk(clk), .rst_n(rst_n), .load(ref_acc), .load_val(rfc_load), .zero(rfc_zero)
    );
    ddr_gap_downcnt #(.WIDTH(GAP_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(wr_last), .load_val(wr_load), .zero(wr_zero)
    );
    ddr_gap_downcnt #(.WIDTH(GAP_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(act_acc), .load_val(rrd_load), .zero(rrd_zero)
    );
    ddr_gap_downcnt #(.WIDTH(GAP_W)) u_wtr (
        .clk(clk), .rst_n(rst_n), .load(wr_last), .load_val(wtr_load), .zero(wtr_zero)
    );

    // Remember which bank the last accepted activate opened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bank_q <= '0;
        end else if (act_acc) begin
            last_bank_q <= bank_in;
        end
    end

    // Permission per command type for the offered bank.
    always_comb begin
        act_ok = rfc_zero && (rrd_zero || (bank_in == last_bank_q));
        pre_ok = wr_zero;
        rd_ok  = wtr_zero;
        idle   = rfc_zero && wr_zero && rrd_zero && wtr_zero;
    end
endmodule

// File: rtl/ddr_cmd_gap_enforcer.sv
// Top: holds each offered DDR command until the intervals on its chip
// select have elapsed. One timer per chip select; shared shadow settings.
// Assumes: cmd_* are stable while cmd_valid is high and cmd_ready is low.
module ddr_cmd_gap_enforcer
    import ddr_gap_pkg::*;
#(
    parameter  int NUM_CS   = 4,
    parameter  int NUM_BANK = 8,
    localparam int CS_W     = $clog2(NUM_CS),
    localparam int BANK_W   = $clog2(NUM_BANK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CMD_W-1:0]    cmd_type,
    input  logic [CS_W-1:0]     cmd_cs,
    input  logic [BANK_W-1:0]   cmd_bank,
    output logic                cmd_ready,
    input  logic [NUM_CS-1:0]   wr_last,
    input  logic [RFC_LO_W-1:0] cfg_rfc_lo,
    input  logic [RFC_HI_W-1:0] cfg_rfc_hi,
    input  logic [GAP_W-1:0]    cfg_wr_rec,
    input  logic [GAP_W-1:0]    cfg_act_gap,
    input  logic [GAP_W-1:0]    cfg_wr_to_rd,
    output logic                cfg_err
);
    logic                 cmd_accept;
    logic                 all_idle;
    logic [RFC_CNT_W-1:0] rfc_load;
    logic [GAP_W-1:0]     wr_load;
    logic [GAP_W-1:0]     rrd_load;
    logic [GAP_W-1:0]     wtr_load;
    logic [NUM_CS-1:0]    act_ok_v;
    logic [NUM_CS-1:0]    pre_ok_v;
    logic [NUM_CS-1:0]    rd_ok_v;
    logic [NUM_CS-1:0]    idle_v;

    assign cmd_accept = cmd_valid && cmd_ready;
    assign all_idle   = &idle_v;

    ddr_gap_cfg_shadow u_cfg (
        .clk(clk), .rst_n(rst_n), .capture_en(all_idle),
        .raw_rfc_lo(cfg_rfc_lo), .raw_rfc_hi(cfg_rfc_hi),
        .raw_wr(cfg_wr_rec), .raw_rrd(cfg_act_gap), .raw_wtr(cfg_wr_to_rd),
        .rfc_load(rfc_load), .wr_load(wr_load), .rrd_load(rrd_load),
        .wtr_load(wtr_load), .cfg_err(cfg_err)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        logic hit;
        assign hit = cmd_accept && (cmd_cs == CS_W'(g));

        ddr_gap_cs_timer #(.BANK_W(BANK_W)) u_timer (
            .clk(clk), .rst_n(rst_n),
            .act_acc(hit && (cmd_type == CMD_ACT)),
            .ref_acc(hit && (cmd_type == CMD_REF)),
            .wr_last(wr_last[g]),
            .bank_in(cmd_bank),
            .rfc_load(rfc_load), .wr_load(wr_load),
            .rrd_load(rrd_load), .wtr_load(wtr_load),
            .act_ok(act_ok_v[g]), .pre_ok(pre_ok_v[g]),
            .rd_ok(rd_ok_v[g]), .idle(idle_v[g])
        );
    end

    // Grant from the addressed chip select's permissions.
    always_comb begin
        case (cmd_type)
            CMD_ACT: cmd_ready = act_ok_v[cmd_cs];
            CMD_PRE: cmd_ready = pre_ok_v[cmd_cs];
            CMD_RD:  cmd_ready = rd_ok_v[cmd_cs];
            default: cmd_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/ddr_gap_checker.sv
// Interval properties for ddr_cmd_gap_enforcer, bound onto the top.
// Assumes: the shadow load values are the interval lengths minus one.
module ddr_gap_checker
    import ddr_gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CMD_W-1:0]  cmd_type,
    input logic [CS_W-1:0]   cmd_cs,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [NUM_CS-1:0] wr_last,
    input logic              cfg_err,
    input logic [GAP_W-1:0]  wr_load,
    input logic [GAP_W-1:0]  rrd_load,
    input logic [GAP_W-1:0]  wtr_load
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    // R5: error flag never clears outside reset.
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R7: write, refresh and unused codes are never held.
    a_r7_free_types: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_type >= CMD_WR) |-> cmd_ready);

    for (genvar c = 0; c < NUM_CS; c++) begin : g_chk
        // R1: no activate the cycle after a refresh on that chip select.
        a_r1_ref_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && cmd_type == CMD_REF && cmd_cs == CS_W'(c))
            |=> !(acc && cmd_type == CMD_ACT && cmd_cs == CS_W'(c)));

        // R2: precharge held right after last write data when length > 1.
        a_r2_wr_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_last[c] && wr_load != '0)
            |=> !(acc && cmd_type == CMD_PRE && cmd_cs == CS_W'(c)));

        // R4: read held right after last write data when length > 1.
        a_r4_wr_blocks_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_last[c] && wtr_load != '0)
            |=> !(acc && cmd_type == CMD_RD && cmd_cs == CS_W'(c)));

        // R3: other-bank activate held right after an activate when length > 1.
        a_r3_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && cmd_type == CMD_ACT && cmd_cs == CS_W'(c) && rrd_load != '0)
            |=> !(acc && cmd_type == CMD_ACT && cmd_cs == CS_W'(c)
                  && cmd_bank != $past(cmd_bank)));
    end
endmodule

bind ddr_cmd_gap_enforcer ddr_gap_checker #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .BANK_W(BANK_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_cs(cmd_cs), .cmd_bank(cmd_bank),
    .wr_last(wr_last), .cfg_err(cfg_err), .wr_load(wr_load),
    .rrd_load(rrd_load), .wtr_load(wtr_load)
);

// File: tb/ddr_cmd_gap_enforcer_tb_top.sv
`timescale 1ns/1ps
// Bench: a model of the interval rules predicts cmd_ready and cfg_err every
// cycle; directed sequences hit the corner lengths and the shadow capture.
module ddr_cmd_gap_enforcer_tb_top;
    import ddr_gap_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_type = '0;
    logic [1:0] cmd_cs = '0;
    logic [2:0] cmd_bank = '0;
    logic       cmd_ready;
    logic [3:0] wr_last = '0;
    logic [3:0] cfg_rfc_lo = '0;
    logic [2:0] cfg_rfc_hi = '0;
    logic [2:0] cfg_wr_rec = 3'd1;
    logic [2:0] cfg_act_gap = 3'd1;
    logic [2:0] cfg_wr_to_rd = 3'd1;
    logic       cfg_err;

    always #2 clk = ~clk;

    ddr_cmd_gap_enforcer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_ready(cmd_ready),
        .wr_last(wr_last), .cfg_rfc_lo(cfg_rfc_lo), .cfg_rfc_hi(cfg_rfc_hi),
        .cfg_wr_rec(cfg_wr_rec), .cfg_act_gap(cfg_act_gap),
        .cfg_wr_to_rd(cfg_wr_to_rd), .cfg_err(cfg_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    int t = 0;
    int f_rfc[4], f_wr[4], f_rrd[4], f_wtr[4], lb[4];
    int s_rfc, s_wr, s_rrd, s_wtr;
    bit e_err;
    int n_lo = 0, n_hi = 0, n_wr = 1, n_rrd = 1, n_wtr = 1;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit exp_rdy(input int ty, input int cs, input int bk);
        case (ty)
            0: return (t >= f_rfc[cs]) && ((t >= f_rrd[cs]) || (bk == lb[cs]));
            1: return t >= f_wr[cs];
            2: return t >= f_wtr[cs];
            default: return 1'b1;
        endcase
    endfunction

    function automatic string tag(input int ty);
        case (ty)
            0: return "R1/R3 act";
            1: return "R2 pre";
            2: return "R4 rd";
            default: return "R7 free";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
        end
    endtask

    // One cycle: drive, check against the model, then advance the model.
    task automatic step(input bit v, input int ty, input int cs, input int bk,
                        input logic [3:0] wl, output bit rdy);
        bit e;
        bit all_free;
        @(negedge clk);
        cmd_valid = v; cmd_type = 3'(ty); cmd_cs = 2'(cs); cmd_bank = 3'(bk);
        wr_last = wl;
        cfg_rfc_lo = 4'(n_lo); cfg_rfc_hi = 3'(n_hi); cfg_wr_rec = 3'(n_wr);
        cfg_act_gap = 3'(n_rrd); cfg_wr_to_rd = 3'(n_wtr);
        #1;
        e = exp_rdy(ty, cs, bk);
        check(cmd_ready === e, tag(ty), int'(cmd_ready), int'(e));
        check(cfg_err === e_err, "R5 cfg_err", int'(cfg_err), int'(e_err));
        rdy = cmd_ready;
        all_free = 1'b1;
        for (int c = 0; c < 4; c++)
            if (f_rfc[c] > t || f_wr[c] > t || f_rrd[c] > t || f_wtr[c] > t) all_free = 1'b0;
        if (v && e) begin
            if (ty == 0) begin f_rrd[cs] = t + eff(s_rrd); lb[cs] = bk; end
            if (ty == 4) f_rfc[cs] = t + s_rfc + 8;
        end
        for (int c = 0; c < 4; c++)
            if (wl[c]) begin f_wr[c] = t + eff(s_wr); f_wtr[c] = t + eff(s_wtr); end
        if (all_free) begin
            s_rfc = n_hi * 16 + n_lo; s_wr = n_wr; s_rrd = n_rrd; s_wtr = n_wtr;
            if (n_wr == 0 || n_rrd == 0 || n_wtr == 0) e_err = 1'b1;
        end
        t++;
    endtask

    task automatic idle(input int n);
        bit r;
        for (int i = 0; i < n; i++) step(1'b0, 3, 0, 0, 4'b0, r);
    endtask

    // Offer one command until accepted; return the cycles it was held.
    task automatic hold_count(input int ty, input int cs, input int bk, output int lows);
        bit r;
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            step(1'b1, ty, cs, bk, 4'b0, r);
            if (r) break;
            lows++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; wr_last = '0;
        cfg_rfc_lo = 4'(n_lo); cfg_rfc_hi = 3'(n_hi); cfg_wr_rec = 3'(n_wr);
        cfg_act_gap = 3'(n_rrd); cfg_wr_to_rd = 3'(n_wtr);
        repeat (2) @(negedge clk);
        for (int ty = 0; ty < 5; ty++) begin
            cmd_type = 3'(ty); cmd_valid = 1'b1;
            #0.2;
            check(cmd_ready === 1'b1, "R9 ready in reset", int'(cmd_ready), 1);
        end
        check(cfg_err === 1'b0, "R9 err in reset", int'(cfg_err), 0);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            f_rfc[c] = -1; f_wr[c] = -1; f_rrd[c] = -1; f_wtr[c] = -1; lb[c] = 0;
        end
        s_rfc = n_hi * 16 + n_lo; s_wr = n_wr; s_rrd = n_rrd; s_wtr = n_wtr;
        e_err = (n_wr == 0 || n_rrd == 0 || n_wtr == 0);
        t = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int lows;
        bit r;
        void'($urandom(32'd20240611));

        // R1: longest refresh recovery, 135 clocks.
        n_lo = 15; n_hi = 7; n_wr = 1; n_rrd = 1; n_wtr = 1;
        do_reset();
        step(1'b1, 4, 0, 0, 4'b0, r);
        hold_count(0, 0, 1, lows);
        check(lows == 134, "R1 max held cycles", lows, 134);

        // R1: shortest refresh recovery, 8 clocks.
        n_lo = 0; n_hi = 0;
        idle(3);
        step(1'b1, 4, 1, 0, 4'b0, r);
        hold_count(0, 1, 0, lows);
        check(lows == 7, "R1 min held cycles", lows, 7);

        // R3: same bank free, other bank spaced by 7.
        n_rrd = 7;
        idle(3);
        step(1'b1, 0, 0, 2, 4'b0, r);
        step(1'b1, 0, 0, 2, 4'b0, r);
        check(r == 1'b1, "R3 same bank ready", int'(r), 1);
        hold_count(0, 0, 5, lows);
        check(lows == 6, "R3 other bank held cycles", lows, 6);

        // R6: refresh on one chip select leaves another free.
        n_lo = 15; n_hi = 7;
        idle(10);
        step(1'b1, 4, 2, 0, 4'b0, r);
        step(1'b1, 0, 3, 4, 4'b0, r);
        check(r == 1'b1, "R6 other cs ready", int'(r), 1);
        step(1'b0, 0, 2, 0, 4'b0, r);
        check(r == 1'b0, "R6 own cs held", int'(r), 0);
        idle(140);

        // R4 and R2: intervals from the last write data strobe.
        n_lo = 0; n_hi = 0; n_rrd = 1; n_wtr = 4; n_wr = 5;
        idle(3);
        step(1'b0, 3, 0, 0, 4'b0001, r);
        hold_count(2, 0, 0, lows);
        check(lows == 3, "R4 read held cycles", lows, 3);
        step(1'b0, 3, 0, 0, 4'b0010, r);
        hold_count(1, 1, 0, lows);
        check(lows == 4, "R2 precharge held cycles", lows, 4);

        // R5: reserved zero acts as one clock and sets a sticky flag.
        n_wr = 0;
        idle(8);
        check(cfg_err === 1'b1, "R5 err set", int'(cfg_err), 1);
        step(1'b0, 3, 0, 0, 4'b0010, r);
        step(1'b1, 1, 1, 0, 4'b0, r);
        check(r == 1'b1, "R5 zero acts as one", int'(r), 1);
        n_wr = 3;
        idle(4);
        check(cfg_err === 1'b1, "R5 err sticky", int'(cfg_err), 1);

        // R8: settings change while a counter runs is deferred.
        n_wr = 1; n_lo = 4; n_hi = 0;
        idle(4);
        step(1'b1, 4, 2, 0, 4'b0, r);
        n_wr = 7;
        step(1'b0, 3, 0, 0, 4'b1000, r);
        step(1'b1, 1, 3, 0, 4'b0, r);
        check(r == 1'b1, "R8 old setting used", int'(r), 1);
        idle(20);
        step(1'b0, 3, 0, 0, 4'b1000, r);
        step(1'b1, 1, 3, 0, 4'b0, r);
        check(r == 1'b0, "R8 new setting used", int'(r), 0);
        idle(10);

        // Reset clears the sticky flag (R9), then random traffic (R7).
        n_wr = 2; n_rrd = 3; n_wtr = 2; n_lo = 3; n_hi = 1;
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] wl;
            if (i % 200 == 199) begin
                n_lo = $urandom_range(0, 15); n_hi = $urandom_range(0, 7);
                n_wr = $urandom_range(0, 7); n_rrd = $urandom_range(0, 7);
                n_wtr = $urandom_range(0, 7);
            end
            for (int c = 0; c < 4; c++) wl[c] = ($urandom_range(0, 7) == 0);
            step(($urandom_range(0, 3) != 0), $urandom_range(0, 5),
                 $urandom_range(0, 3), $urandom_range(0, 2), wl, r);
        end

        summary();
        $finish;
    end
endmodule